// File: doc/BRIEF.md
# Card Tuple Chain Walker

This block traverses a linked list of variable-length descriptor records held in the byte-wide attribute memory of a removable card. Every record opens with a one-byte type code. A one-byte link follows it and gives the number of bytes that come after the link within the same record. The attribute memory only returns data at even card addresses, so record byte k sits at physical address base + 2k. A single start pulse makes the walker begin at address zero. It follows the links until a terminator is reached, or until one of its safety limits stops it.

The walker has two modes. In listing mode it presents every record on a valid/ready output port, giving the type code, the physical start address and the raw link byte. In search mode it emits no records. It looks for one requested type code and ends with a found flag and the matching start address, or with found clear if the chain ends first. The only other interface is a request/acknowledge read port to the memory. At most one read is outstanding, and the port accepts any read latency.

Top module: `tuple_chain_walker`

## Requirements
- R1: After a start pulse from idle, the first memory read is issued at address 0.
- R2: For a record at base B, the code byte is read at B and the link byte at B+2. The next record starts at B + 2*(2+link).
- R3: A code byte of 0xFF ends the walk. The link byte at B+2 is not read, the record is not reported, and done pulses with found=0 and err=0.
- R4: A link byte of 0xFF marks the last record. In listing mode that record is reported, and then done pulses with found=0 and err=0.
- R5: A link byte of 0x00 is legal. The next record starts at B+4.
- R6: In listing mode each record is shown with rec_valid=1, rec_code=code, rec_addr=B and rec_len=link byte. These values stay stable until rec_ready is seen high. Body bytes are never read.
- R7: In search mode no record is emitted. When a record's code equals search_code (including 0x01), done pulses with found=1 and found_addr=B.
- R8: In search mode, if the chain ends by either terminator before a match, done pulses with found=0 and err=0.
- R9: Once MAX_RECS records have been passed, the walk stops with done, err=1 and found=0.
- R10: A record base above ADDR_LIMIT-2 is not read. The walk stops with done, err=1 and found=0.
- R11: Only one read is outstanding at a time. mem_req stays high with a stable mem_addr until mem_ack, and drops in the cycle after mem_ack.
- R12: While rst_n is low the block returns to idle, with mem_req, rec_valid, done, found and err all 0. A start pulse during a walk has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| search_en | input | 1 | Search mode when 1, listing mode when 0; sampled at start |
| search_code | input | 8 | Type code to search for; sampled at start |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | AW | Read address |
| mem_ack | input | 1 | Read acknowledge, one cycle, data valid with it |
| mem_data | input | 8 | Read data |
| rec_valid | output | 1 | A record is presented |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_code | output | 8 | Record type code |
| rec_addr | output | AW | Record start address |
| rec_len | output | 8 | Raw link byte of the record |
| done | output | 1 | One-cycle pulse at the end of a walk |
| found | output | 1 | Search matched; held until next start |
| found_addr | output | AW | Start address of the matching record |
| err | output | 1 | Walk stopped by a safety limit; held until next start |

## Verification
Listing runs use chains that end by a 0xFF code and chains that end by a 0xFF link. This shows that the first kind is not reported while the second is. Chains made only of empty records separate the B+4 step from a miscounted body. Body bytes filled with 0xFF show that the body is never read as a code. Search runs match the first record, a middle record and a last-link record, and also miss. An all-zero memory and a chain of long records exercise the two safety limits, and a second start pulse in mid-walk checks that the first walk completes unchanged.

// File: rtl/tcw_pkg.sv
// Shared types and constants for the tuple chain walker.
// Assumes byte-wide records whose code and link use 0xFF as terminators.
package tcw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WCODE,
        ST_WLINK,
        ST_EMIT
    } tcw_state_t;

    localparam logic [7:0] CODE_END  = 8'hFF;
    localparam logic [7:0] LINK_LAST = 8'hFF;
endpackage

// File: rtl/tcw_rd_port.sv
// Single-outstanding read port. It turns a one-cycle go into a held
// request and returns one registered data byte with a done pulse.
// Assumes go is issued only while no request is pending.
module tcw_rd_port #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] go_addr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [7:0]    mem_data,
    output logic          rd_done,
    output logic [7:0]    rd_data
);
    // Hold the request until acknowledged, then capture the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req  <= 1'b0;
            mem_addr <= '0;
            rd_done  <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_done <= 1'b0;
            if (mem_req && mem_ack) begin
                mem_req <= 1'b0;
                rd_data <= mem_data;
                rd_done <= 1'b1;
            end else if (go && !mem_req) begin
                mem_req  <= 1'b1;
                mem_addr <= go_addr;
            end
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R11
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req); // R11
endmodule

// File: rtl/tcw_guard.sv
// Safety limits for the walk: counts the records passed and flags a base
// address beyond the readable bound. Assumes clr comes at walk start and
// inc once for each record advanced past.
module tcw_guard #(
    parameter int BW         = 14,
    parameter int MAX_RECS   = 64,
    parameter int ADDR_LIMIT = 4094
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [BW-1:0] base,
    output logic          stop
);
    localparam int CW = $clog2(MAX_RECS + 1);

    logic [CW-1:0] cnt;

    // Count the records advanced past during the current walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CW'(1);
        end
    end

    // Stop when the count limit is reached or the link byte would be out of bound.
    always_comb begin
        stop = (cnt == CW'(MAX_RECS)) || (base > BW'(ADDR_LIMIT - 2));
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAX_RECS)); // R9
endmodule

// File: rtl/tcw_fsm.sv
// Walk sequencer: it reads code and link per record, decides whether to
// stop, emit, match or advance, and holds the current record base.
// Assumes the read port accepts a go only when idle and returns one byte.
module tcw_fsm
    import tcw_pkg::*;
#(
    parameter int AW = 12,
    parameter int BW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          search_en,
    input  logic [7:0]    search_code,
    output logic          rd_go,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_done,
    input  logic [7:0]    rd_data,
    input  logic          guard_stop,
    output logic          guard_clr,
    output logic          guard_inc,
    output logic [BW-1:0] base,
    output logic          rec_valid,
    input  logic          rec_ready,
    output logic [7:0]    rec_code,
    output logic [AW-1:0] rec_addr,
    output logic [7:0]    rec_len,
    output logic          done,
    output logic          found,
    output logic [AW-1:0] found_addr,
    output logic          err
);
    tcw_state_t    state;
    logic [7:0]    code_q;
    logic [7:0]    link_q;
    logic          srch_q;
    logic [7:0]    scode_q;
    logic [7:0]    adv_link;
    logic [BW-1:0] base_next;
    logic          adv;

    // Choose the link that sets the step and compute the next record base.
    always_comb begin
        adv_link  = (state == ST_EMIT) ? link_q : rd_data;
        base_next = base + BW'({adv_link, 1'b0}) + BW'(4);
        adv = ((state == ST_WLINK) && rd_done && srch_q && (code_q != scode_q)
                  && (rd_data != LINK_LAST))
           || ((state == ST_EMIT) && rec_ready && (link_q != LINK_LAST));
    end

    // Issue reads: code at the base, link two addresses above it.
    always_comb begin
        rd_go   = 1'b0;
        rd_addr = base[AW-1:0];
        if (state == ST_CHECK) begin
            rd_go = !guard_stop;
        end else if (state == ST_WCODE) begin
            rd_go   = rd_done && (rd_data != CODE_END);
            rd_addr = base[AW-1:0] + AW'(2);
        end
    end

    // Drive the guard counter and the record port.
    always_comb begin
        guard_clr = (state == ST_IDLE) && start;
        guard_inc = adv;
        rec_valid = (state == ST_EMIT);
        rec_code  = code_q;
        rec_addr  = base[AW-1:0];
        rec_len   = link_q;
    end

    // Main walk sequence and the result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            base       <= '0;
            code_q     <= '0;
            link_q     <= '0;
            srch_q     <= 1'b0;
            scode_q    <= '0;
            done       <= 1'b0;
            found      <= 1'b0;
            found_addr <= '0;
            err        <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        base       <= '0;
                        srch_q     <= search_en;
                        scode_q    <= search_code;
                        found      <= 1'b0;
                        found_addr <= '0;
                        err        <= 1'b0;
                        state      <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (guard_stop) begin
                        err   <= 1'b1;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_WCODE;
                    end
                end
                ST_WCODE: begin
                    if (rd_done) begin
                        code_q <= rd_data;
                        if (rd_data == CODE_END) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_WLINK;
                        end
                    end
                end
                ST_WLINK: begin
                    if (rd_done) begin
                        link_q <= rd_data;
                        if (!srch_q) begin
                            state <= ST_EMIT;
                        end else if (code_q == scode_q) begin
                            found      <= 1'b1;
                            found_addr <= base[AW-1:0];
                            done       <= 1'b1;
                            state      <= ST_IDLE;
                        end else if (rd_data == LINK_LAST) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            base  <= base_next;
                            state <= ST_CHECK;
                        end
                    end
                end
                ST_EMIT: begin
                    if (rec_ready) begin
                        if (link_q == LINK_LAST) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            base  <= base_next;
                            state <= ST_CHECK;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_CODE_END_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WCODE) && rd_done && (rd_data == CODE_END)
        |=> done && !found && !err && !rd_go); // R3
    AST_LAST_LINK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_ready && (rec_len == LINK_LAST) |=> done && !rec_valid); // R4
    AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec_ready |=> rec_valid && $stable(rec_code)
            && $stable(rec_addr) && $stable(rec_len)); // R6
    AST_SEARCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        srch_q |-> !rec_valid); // R7
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(found && err)); // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WCODE) && !rd_done && start |=> (state == ST_WCODE)); // R12
endmodule

// File: rtl/tuple_chain_walker.sv
// Top of the tuple chain walker: read port, limit guard and walk sequencer.
// Assumes attribute bytes sit at even addresses and the memory answers each
// request with exactly one acknowledge.
module tuple_chain_walker #(
    parameter int AW         = 12,
    parameter int MAX_RECS   = 64,
    parameter int ADDR_LIMIT = (1 << AW) - 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          search_en,
    input  logic [7:0]    search_code,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [7:0]    mem_data,
    output logic          rec_valid,
    input  logic          rec_ready,
    output logic [7:0]    rec_code,
    output logic [AW-1:0] rec_addr,
    output logic [7:0]    rec_len,
    output logic          done,
    output logic          found,
    output logic [AW-1:0] found_addr,
    output logic          err
);
    localparam int BW = AW + 2;

    logic          rd_go;
    logic [AW-1:0] rd_addr;
    logic          rd_done;
    logic [7:0]    rd_data;
    logic          guard_stop;
    logic          guard_clr;
    logic          guard_inc;
    logic [BW-1:0] base;

    tcw_rd_port #(.AW(AW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (rd_go),
        .go_addr  (rd_addr),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .mem_ack  (mem_ack),
        .mem_data (mem_data),
        .rd_done  (rd_done),
        .rd_data  (rd_data)
    );

    tcw_guard #(.BW(BW), .MAX_RECS(MAX_RECS), .ADDR_LIMIT(ADDR_LIMIT)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (guard_clr),
        .inc   (guard_inc),
        .base  (base),
        .stop  (guard_stop)
    );

    tcw_fsm #(.AW(AW), .BW(BW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .search_en   (search_en),
        .search_code (search_code),
        .rd_go       (rd_go),
        .rd_addr     (rd_addr),
        .rd_done     (rd_done),
        .rd_data     (rd_data),
        .guard_stop  (guard_stop),
        .guard_clr   (guard_clr),
        .guard_inc   (guard_inc),
        .base        (base),
        .rec_valid   (rec_valid),
        .rec_ready   (rec_ready),
        .rec_code    (rec_code),
        .rec_addr    (rec_addr),
        .rec_len     (rec_len),
        .done        (done),
        .found       (found),
        .found_addr  (found_addr),
        .err         (err)
    );
endmodule

// File: tb/tb_tuple_chain_walker.sv
module tb_tuple_chain_walker;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 12;
    localparam int MSZ  = 1 << AW;
    localparam int LAT  = 3;
    localparam int NVEC = 8;

    typedef struct packed {
        logic [2:0]  n;
        logic [31:0] codes;
        logic [31:0] links;
        logic        srch;
        logic [7:0]  scode;
    } vec_t;

    // Byte i of codes/links is record i (rightmost byte first).
    localparam vec_t VECS [NVEC] = '{
        '{3'd3, 32'h00152001, 32'h00050003, 1'b0, 8'h00},
        '{3'd2, 32'h00001701, 32'h0000FF02, 1'b0, 8'h00},
        '{3'd4, 32'h13121110, 32'h00000000, 1'b0, 8'h00},
        '{3'd3, 32'h00300120, 32'h00000104, 1'b1, 8'h01},
        '{3'd3, 32'h00222120, 32'h00FF0201, 1'b1, 8'h99},
        '{3'd0, 32'h00000000, 32'h00000000, 1'b0, 8'h00},
        '{3'd2, 32'h00000605, 32'h0000FF07, 1'b1, 8'h06},
        '{3'd2, 32'h00003301, 32'h00000000, 1'b1, 8'h01}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          search_en = 1'b0;
    logic [7:0]    search_code = 8'h00;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_ack;
    logic [7:0]    mem_data;
    logic          rec_valid;
    logic          rec_ready;
    logic [7:0]    rec_code;
    logic [AW-1:0] rec_addr;
    logic [7:0]    rec_len;
    logic          done;
    logic          found;
    logic [AW-1:0] found_addr;
    logic          err;

    int n_tests = 0;
    int n_fail  = 0;

    tuple_chain_walker #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .search_en(search_en),
        .search_code(search_code), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_data(mem_data), .rec_valid(rec_valid),
        .rec_ready(rec_ready), .rec_code(rec_code), .rec_addr(rec_addr),
        .rec_len(rec_len), .done(done), .found(found),
        .found_addr(found_addr), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: fixed latency, one acknowledge per accepted request.
    logic [7:0]    mem [0:MSZ-1];
    logic          busy;
    int            lcnt;
    logic [AW-1:0] a_q;
    int            rd_n = 0;
    logic [AW-1:0] rd_log [0:255];
    int            hold_viol = 0;
    int            watch_hits = 0;
    logic [AW-1:0] watch_addr = '1;

    always @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            mem_ack  <= 1'b0;
            mem_data <= 8'h00;
            lcnt     <= 0;
            a_q      <= '0;
        end else begin
            mem_ack <= 1'b0;
            if (busy) begin
                if (!mem_req || mem_addr != a_q) hold_viol <= hold_viol + 1;
                if (lcnt == 0) begin
                    mem_ack  <= 1'b1;
                    mem_data <= mem[a_q];
                    busy     <= 1'b0;
                end else begin
                    lcnt <= lcnt - 1;
                end
            end else if (mem_req && !mem_ack) begin
                busy <= 1'b1;
                lcnt <= LAT - 1;
                a_q  <= mem_addr;
                rd_log[rd_n[7:0]] <= mem_addr;
                rd_n <= rd_n + 1;
                if (mem_addr == watch_addr) watch_hits <= watch_hits + 1;
            end
        end
    end

    // Consumer backpressure: ready low one cycle in four.
    initial begin
        rec_ready = 1'b1;
        for (int ph = 0; ; ph++) begin
            @(negedge clk);
            rec_ready = ((ph % 4) != 1);
        end
    end

    // Watchdog for the whole run.
    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Captured results of one walk.
    int            got_n;
    logic [7:0]    got_code [0:127];
    logic [AW-1:0] got_addr [0:127];
    logic [7:0]    got_len  [0:127];
    int            got_done;
    logic          got_found;
    logic          got_err;
    logic [AW-1:0] got_faddr;
    int            rd0;
    int            viol0;
    int            watch0;
    int            ex_addr [0:3];
    int            term;

    task automatic clear_mem(input logic [7:0] v);
        for (int a = 0; a < MSZ; a++) mem[a] = v;
    endtask

    task automatic build(input vec_t v);
        int b;
        logic [7:0] lk;
        clear_mem(8'h00);
        b = 0;
        for (int i = 0; i < int'(v.n); i++) begin
            lk = v.links[8*i +: 8];
            mem[b]     = v.codes[8*i +: 8];
            mem[b + 2] = lk;
            if (lk != 8'hFF)
                for (int k = 0; k < int'(lk); k++) mem[b + 4 + 2*k] = 8'hFF;
            ex_addr[i] = b;
            b = b + 2*(2 + int'(lk));
        end
        term = b;
        if (v.n == 0 || v.links[8*(int'(v.n)-1) +: 8] != 8'hFF) mem[term] = 8'hFF;
    endtask

    task automatic run(input logic s, input logic [7:0] c, input int restart_gap);
        int guard;
        got_n = 0;
        got_done = 0;
        got_found = 1'b0;
        got_err = 1'b0;
        got_faddr = '0;
        rd0 = rd_n;
        viol0 = hold_viol;
        watch0 = watch_hits;
        @(negedge clk);
        search_en = s;
        search_code = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (got_done == 0 && guard < 20000) begin
            if (restart_gap > 0 && guard == restart_gap) start = 1'b1;
            else start = 1'b0;
            if (rec_valid && rec_ready && got_n < 128) begin
                got_code[got_n] = rec_code;
                got_addr[got_n] = rec_addr;
                got_len[got_n]  = rec_len;
                got_n++;
            end
            if (done) begin
                got_done++;
                got_found = found;
                got_err = err;
                got_faddr = found_addr;
            end
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        if (guard >= 20000) chk("watchdog per walk", 0, 1);
        for (int t = 0; t < 8; t++) begin
            if (done) got_done++;
            if (rec_valid) got_done = got_done + 100;
            @(negedge clk);
        end
    endtask

    initial begin
        clear_mem(8'h00);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 reset mem_req", {31'd0, mem_req}, 0);
        chk("R12 reset rec_valid", {31'd0, rec_valid}, 0);
        chk("R12 reset done", {31'd0, done}, 0);
        chk("R12 reset found/err", {30'd0, found, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table of chains walked by one loop.
        for (int vi = 0; vi < NVEC; vi++) begin
            vec_t v;
            int   exp_idx;
            v = VECS[vi];
            build(v);
            watch_addr = AW'(term + 2);
            run(v.srch, v.scode, 0);
            chk($sformatf("R1 first read addr v%0d", vi), 32'(rd_log[rd0[7:0]]), 0);
            chk($sformatf("R11 request hold v%0d", vi), hold_viol - viol0, 0);
            chk($sformatf("R12 single done v%0d", vi), got_done, 1);
            chk($sformatf("R9 no err v%0d", vi), {31'd0, got_err}, 0);
            if (!v.srch) begin
                chk($sformatf("R2 record count v%0d", vi), got_n, int'(v.n));
                for (int i = 0; i < int'(v.n) && i < got_n; i++) begin
                    chk($sformatf("R2 R5 rec addr v%0d i%0d", vi, i), 32'(got_addr[i]), ex_addr[i]);
                    chk($sformatf("R6 rec code v%0d i%0d", vi, i), 32'(got_code[i]), 32'(v.codes[8*i +: 8]));
                    chk($sformatf("R6 rec len v%0d i%0d", vi, i), 32'(got_len[i]), 32'(v.links[8*i +: 8]));
                end
                chk($sformatf("R3 R4 found clear v%0d", vi), {31'd0, got_found}, 0);
                if (v.n == 0 || v.links[8*(int'(v.n)-1) +: 8] != 8'hFF)
                    chk($sformatf("R3 no link read after end code v%0d", vi), watch_hits - watch0, 0);
            end else begin
                exp_idx = -1;
                for (int i = int'(v.n) - 1; i >= 0; i--)
                    if (v.codes[8*i +: 8] == v.scode) exp_idx = i;
                chk($sformatf("R7 no records in search v%0d", vi), got_n, 0);
                if (exp_idx >= 0) begin
                    chk($sformatf("R7 found v%0d", vi), {31'd0, got_found}, 1);
                    chk($sformatf("R7 found addr v%0d", vi), 32'(got_faddr), ex_addr[exp_idx]);
                end else begin
                    chk($sformatf("R8 not found v%0d", vi), {31'd0, got_found}, 0);
                end
            end
        end

        // R12: a second start in mid-walk does not disturb the walk.
        build(VECS[2]);
        run(1'b0, 8'h00, 12);
        chk("R12 restart ignored count", got_n, 4);
        chk("R12 restart ignored last addr", 32'(got_addr[3]), 12);
        chk("R12 restart ignored single done", got_done, 1);

        // R9: all-zero memory gives endless empty records.
        clear_mem(8'h00);
        run(1'b0, 8'h00, 0);
        chk("R9 count limit records", got_n, 64);
        chk("R9 count limit err", {31'd0, got_err}, 1);
        chk("R9 count limit found", {31'd0, got_found}, 0);
        chk("R9 last record addr", 32'(got_addr[63]), 252);

        // R10: long records run past the address bound.
        clear_mem(8'h00);
        for (int k = 0; k < 11; k++) begin
            mem[k*404]     = 8'h40;
            mem[k*404 + 2] = 8'd200;
        end
        run(1'b0, 8'h00, 0);
        chk("R10 bound records", got_n, 11);
        chk("R10 bound last addr", 32'(got_addr[10]), 4040);
        chk("R10 bound err", {31'd0, got_err}, 1);

        // R12: reset in mid-walk returns to idle.
        build(VECS[0]);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12 mid-walk reset mem_req", {31'd0, mem_req}, 0);
        chk("R12 mid-walk reset rec_valid", {31'd0, rec_valid}, 0);
        chk("R12 mid-walk reset done/found/err", {29'd0, done, found, err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule